// File: doc/BRIEF.md
# Double-Buffered Octal Converter Register Front End

This block is the digital front end of an eight-channel, 14-bit digital-to-analog converter. A host drives an asynchronous parallel write bus made of a data word, a channel number, an active-low select, an active-low write strobe, an active-low load strobe and an active-low clear. Each channel has two stages. The first stage is a staging register that a write fills. The second stage is the converter register that sets the output code. A single load strobe moves every staging register into its converter register at the same time, so all eight outputs change together.

The bus is oversampled by a fast system clock. Every bus line passes through a two-flop synchronizer, and the block detects the rising edge of the write strobe in the clock domain. When the load strobe is held low, the block is transparent: a write reaches the output directly. If a write and an active load fall in the same cycle, the new word is forwarded into the converter register in that cycle.

The clear input does not use the clock. While clear is low, every channel flag selects the sense-ground level. No stored code changes during clear, so each channel shows its own code again as soon as clear is released.

Top module: `dac_dual_stage_regs`

## Requirements
- R1: The channel number selects a channel in straight binary: 0 is the first channel and 7 is the last. Channel i's code appears on `dac_code[14*i+13 : 14*i]`.
- R2: A write takes effect only when the select and the write strobe were both low in the sample just before the write strobe rises. A strobe pulse with the select high changes no register.
- R3: While the synchronized load strobe is low, every converter register takes the value of its staging register, so all affected outputs change on the same clock edge.
- R4: While the load strobe is high, a write changes only the staging register of the addressed channel. Every `dac_code` output holds its value.
- R5: With the load strobe held low, a write shows up on the addressed channel's code, and the other channels keep their codes.
- R6: When a write and an active load occur in the same cycle, the addressed converter register takes the newly written word, not the old staging value.
- R7: While `clr_n` is low, every `gnd_sel` bit is 1. This takes effect at once, without waiting for a clock edge. The codes, and the writes and loads made during clear, behave exactly as they do without clear.
- R8: When `clr_n` returns high, every `gnd_sel` bit drops to 0 and each channel again shows the code held in its converter register.
- R9: During a synchronous reset, all staging and converter registers are zero and every `gnd_sel` bit is 1. The flags stay at 1 until the first clock edge with `rst_n` high.
- R10: Bus pins sampled at clock edge k act at edge k+2. The write strobe edge is detected between the sample at k-1 (low) and the sample at k (high). The data word is straight binary with bit 13 as the MSB, and it passes to the output unchanged, including 0x0000 and 0x3FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 14 | Write data, bit 13 is the MSB |
| bus_chan | input | 3 | Channel number of the write |
| sel_n | input | 1 | Chip select, active low |
| wstb_n | input | 1 | Write strobe, active low; data is taken on its rising edge |
| ld_n | input | 1 | Load strobe, active low, level sensitive |
| clr_n | input | 1 | Asynchronous clear to sense ground, active low |
| dac_code | output | 112 | Eight 14-bit converter codes, channel 0 in the low bits |
| gnd_sel | output | 8 | Per-channel flag: 1 selects the sense-ground output |

## Verification
A staging register that picks up a wrong word cannot be seen while the load strobe is high. It shows on `dac_code` two cycles after the next load sample, so the bench runs load pulses after write sequences with the load held high. A wrong converter register or wrong write decoding changes a port code on the edge where the write acts. Errors in edge detection, select gating or forwarding therefore show within one cycle of the expected update, and the bench compares every channel on every clock. A clear path that depends on the clock would leave `gnd_sel` wrong for a fraction of a cycle, so the bench samples it one time unit after `clr_n` changes in the middle of a cycle.

// File: rtl/dac_front_pkg.sv
// Package: shared constants and helpers for the dual-stage converter front end.
// Assumes: channel count is a power of two so the channel number decodes fully.
package dac_front_pkg;
    localparam int DEF_CHANNELS = 8;
    localparam int DEF_CODE_W   = 14;

    // Number of control lines carried through the synchronizer (select, write, load).
    localparam int CTRL_LINES = 3;

    // Bit width needed to number a given count of channels.
    function automatic int chan_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dac_bus_sync.sv
// Module: two-flop synchronizer for a bundle of asynchronous bus lines.
// Assumes: lines are quasi-static around the strobe edges, so a per-bit
// synchronizer is enough; reset loads the idle pattern given by IDLE.
module dac_bus_sync #(
    parameter int          W    = 20,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two-stage capture of the asynchronous bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= IDLE;
            stage2 <= IDLE;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/dac_write_detect.sv
// Module: finds a qualified write-strobe rising edge and decodes the channel.
// Assumes: inputs are already synchronized; the select must be low together
// with the strobe in the sample before the strobe is seen high.
module dac_write_detect
    import dac_front_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int CODE_W   = DEF_CODE_W,
    localparam int CH_W    = chan_bits(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_s_n,
    input  logic                wstb_s_n,
    input  logic [CH_W-1:0]     chan_s,
    input  logic [CODE_W-1:0]   data_s,
    output logic [CHANNELS-1:0] wr_hit,
    output logic [CODE_W-1:0]   wr_word
);
    logic armed;
    logic wr_pulse;

    // Remember that the previous sample had both select and strobe active.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= !sel_s_n && !wstb_s_n;
    end

    assign wr_pulse = armed && wstb_s_n;
    assign wr_word  = data_s;

    // One-hot channel decode of the qualified write.
    for (genvar i = 0; i < CHANNELS; i++) begin : g_dec
        assign wr_hit[i] = wr_pulse && (chan_s == CH_W'(i));
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit)); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R10
    AST_NO_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s_n || wstb_s_n) |=> (wr_hit == '0)); // R2
endmodule

// File: rtl/dac_channel.sv
// Module: one channel's staging register and converter register.
// Assumes: wr_en is a single-cycle qualified write for this channel and
// load_act is the synchronized, active-high form of the load strobe.
module dac_channel
    import dac_front_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_word,
    input  logic              load_act,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] conv_q;

    // Staging register: takes the word on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (wr_en) stage_q <= wr_word;
    end

    // Converter register: copies staging on load, forwarding a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n)        conv_q <= '0;
        else if (load_act) conv_q <= wr_en ? wr_word : stage_q;
    end

    assign code = conv_q;

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage_q)); // R4
    AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_act |=> $stable(code)); // R4
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && !wr_en) |=> (code == $past(stage_q))); // R3
    AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && wr_en) |=> (code == $past(wr_word))); // R6
endmodule

// File: rtl/dac_dual_stage_regs.sv
// Module: top of the double-buffered eight-channel converter register front end.
// Assumes: the system clock is several times faster than the bus strobes; the
// clear input acts on the ground-select flags combinationally, never on data.
module dac_dual_stage_regs
    import dac_front_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int CODE_W   = DEF_CODE_W,
    localparam int CH_W    = chan_bits(CHANNELS),
    localparam int SYNC_W  = CODE_W + CH_W + CTRL_LINES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CODE_W-1:0]          bus_data,
    input  logic [CH_W-1:0]            bus_chan,
    input  logic                       sel_n,
    input  logic                       wstb_n,
    input  logic                       ld_n,
    input  logic                       clr_n,
    output logic [CHANNELS*CODE_W-1:0] dac_code,
    output logic [CHANNELS-1:0]        gnd_sel
);
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {{(CODE_W + CH_W){1'b0}}, 3'b111};

    logic [SYNC_W-1:0]   sync_bus;
    logic [CODE_W-1:0]   data_s;
    logic [CH_W-1:0]     chan_s;
    logic                sel_s_n;
    logic                wstb_s_n;
    logic                ld_s_n;
    logic [CHANNELS-1:0] wr_hit;
    logic [CODE_W-1:0]   wr_word;
    logic                live_q;

    dac_bus_sync #(.W(SYNC_W), .IDLE(SYNC_IDLE)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_data, bus_chan, sel_n, wstb_n, ld_n}),
        .sync_out (sync_bus)
    );

    assign {data_s, chan_s, sel_s_n, wstb_s_n, ld_s_n} = sync_bus;

    dac_write_detect #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s_n  (sel_s_n),
        .wstb_s_n (wstb_s_n),
        .chan_s   (chan_s),
        .data_s   (data_s),
        .wr_hit   (wr_hit),
        .wr_word  (wr_word)
    );

    // Output-enable flag: low through reset, high from the first clock after it.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // One channel pair of registers and one ground flag per channel.
    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
        dac_channel #(.CODE_W(CODE_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit[i]),
            .wr_word  (wr_word),
            .load_act (!ld_s_n),
            .code     (dac_code[i*CODE_W +: CODE_W])
        );
        assign gnd_sel[i] = !(clr_n && live_q);
    end

    AST_RESET_CODES: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0)); // R9
    AST_CLEAR_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && ld_s_n && $stable(clr_n)) |=> $stable(dac_code)); // R7
endmodule

// File: tb/test_dac_dual_stage_regs.sv
// Bench: behavioural reference model of the dual-stage register front end,
// compared with every channel and flag on every clock.
module test_dac_dual_stage_regs;
    localparam int CLK_P = 10;
    localparam int NCH   = 8;
    localparam int CW    = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   bus_data = '0;
    logic [2:0]      bus_chan = '0;
    logic            sel_n = 1'b1;
    logic            wstb_n = 1'b1;
    logic            ld_n = 1'b1;
    logic            clr_n = 1'b1;
    logic [NCH*CW-1:0] dac_code;
    logic [NCH-1:0]  gnd_sel;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R9 reset";

    // Reference state
    int m_stage [NCH];
    int m_conv  [NCH];
    bit m_live;
    // Pin history: index 0 = newest sample; fields data, chan, sel, wstb, ld
    int h_data [$];
    int h_chan [$];
    bit h_sel  [$];
    bit h_wstb [$];
    bit h_ld   [$];

    dac_dual_stage_regs i_dac_dual_stage_regs (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_chan(bus_chan),
        .sel_n(sel_n), .wstb_n(wstb_n), .ld_n(ld_n), .clr_n(clr_n),
        .dac_code(dac_code), .gnd_sel(gnd_sel)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic push_hist(input int d, input int c, input bit s, input bit w, input bit l);
        h_data.push_front(d); h_chan.push_front(c);
        h_sel.push_front(s);  h_wstb.push_front(w); h_ld.push_front(l);
        if (h_data.size() > 3) begin
            void'(h_data.pop_back()); void'(h_chan.pop_back());
            void'(h_sel.pop_back());  void'(h_wstb.pop_back()); void'(h_ld.pop_back());
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < NCH; i++) begin
            checks++;
            if (int'(dac_code[i*CW +: CW]) != m_conv[i]) begin
                errors++;
                $display("FAIL %s ch%0d code: actual=%h expected=%h at %0t",
                         cur_req, i, dac_code[i*CW +: CW], m_conv[i], $time);
            end
        end
        checks++;
        if (gnd_sel != ((!clr_n || !m_live) ? 8'hFF : 8'h00)) begin
            errors++;
            $display("FAIL %s gnd_sel: actual=%h expected=%h at %0t", cur_req, gnd_sel,
                     (!clr_n || !m_live) ? 8'hFF : 8'h00, $time);
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) push_hist(0, 0, 1, 1, 1);
        foreach (m_stage[i]) begin m_stage[i] = 0; m_conv[i] = 0; end
        m_live = 0;
    end

    // Model update on each edge, then compare a quarter period later.
    always @(posedge clk) begin
        int  nd, nc;
        bit  pulse, load;
        int  old_stage [NCH];
        if (!rst_n) begin
            foreach (m_stage[i]) begin m_stage[i] = 0; m_conv[i] = 0; end
            m_live = 0;
            for (int i = 0; i < 3; i++) push_hist(0, 0, 1, 1, 1);
        end else begin
            // Sample from two edges ago acts now (R10)
            pulse = h_wstb[1] && !h_wstb[2] && !h_sel[2];
            load  = !h_ld[1];
            nd    = h_data[1];
            nc    = h_chan[1];
            old_stage = m_stage;
            if (pulse) m_stage[nc] = nd;
            if (load)
                for (int i = 0; i < NCH; i++)
                    m_conv[i] = (pulse && nc == i) ? nd : old_stage[i];
            m_live = 1;
            push_hist(int'(bus_data), int'(bus_chan), sel_n, wstb_n, ld_n);
        end
        #(CLK_P/4);
        compare_all();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input int c, input int d, input bit use_sel);
        @(negedge clk);
        bus_chan = 3'(c); bus_data = CW'(d); sel_n = !use_sel; wstb_n = 1'b0;
        idle(2);
        wstb_n = 1'b1;
        idle(1);
        sel_n = 1'b1;
        idle(1);
    endtask

    task automatic load_pulse();
        @(negedge clk); ld_n = 1'b0;
        idle(2);
        ld_n = 1'b1;
        idle(3);
    endtask

    initial begin
        cur_req = "R9 reset";
        idle(4);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R4 staging only";
        for (int i = 0; i < NCH; i++) bus_write(i, 16'h0111 * (i + 1), 1);
        idle(3);

        cur_req = "R3 R1 simultaneous load";
        load_pulse();

        cur_req = "R2 write without select";
        bus_write(3, 14'h1ABC, 0);
        load_pulse();

        cur_req = "R10 code extremes";
        bus_write(0, 14'h3FFF, 1);
        bus_write(7, 14'h0000, 1);
        bus_write(4, 14'h2000, 1);
        load_pulse();

        cur_req = "R5 transparent load low";
        @(negedge clk); ld_n = 1'b0;
        bus_write(2, 14'h0F0F, 1);
        bus_write(6, 14'h3C3C, 1);
        bus_write(1, 14'h1FFF, 1);

        cur_req = "R6 forward write with load";
        bus_write(5, 14'h2AAA, 1);
        @(negedge clk); ld_n = 1'b1;
        idle(3);

        cur_req = "R7 asynchronous clear";
        @(negedge clk);
        #(CLK_P/8) clr_n = 1'b0;
        #1;
        checks++;
        if (gnd_sel != 8'hFF) begin
            errors++;
            $display("FAIL R7 immediate clear: actual=%h expected=ff", gnd_sel);
        end
        bus_write(3, 14'h0123, 1);
        load_pulse();
        bus_write(0, 14'h0456, 1);
        idle(3);

        cur_req = "R8 clear release";
        @(negedge clk);
        #(CLK_P/8) clr_n = 1'b1;
        #1;
        checks++;
        if (gnd_sel != 8'h00) begin
            errors++;
            $display("FAIL R8 release: actual=%h expected=00", gnd_sel);
        end
        load_pulse();
        idle(2);

        cur_req = "R9 second reset";
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule